// File: doc/BRIEF.md
# Push-Button Press Confirmation Filter

This block cleans up the level from one mechanical push-button. The button line is pulled up, so the contact reads low while the button is held. The raw level is brought into the clock domain and then watched by a small state machine with three states: idle, waiting and confirmed.

When the button first reads down, the block ignores the input for a fixed settling time. When that time is up it takes one more sample. It declares a press only if that sample still reads down. Otherwise it goes back to idle and reports nothing. Once a press is confirmed, the first sample that reads up ends it at once, with no filtering. The filter is therefore deliberately lopsided: pressing is slow and verified, releasing is fast.

The settling time is given in milliseconds together with the clock frequency. Downstream logic can use either the level output or the one-cycle edge pulses.

Top module: `btn_confirm_debounce`

## Requirements
- R1: The input is active low: a raw level of 0 means the button is held, and 1 means it is released.
- R2: The settling time in clock cycles is W = CLK_HZ * WAIT_MS / 1000, with a minimum of 1. The default WAIT_MS is 20.
- R3: Suppose the raw level is first captured low at clock edge k while idle. The block then takes its second sample of the raw level at edge k+W. It raises `pressed` after edge k+W+2 only if that second sample reads low.
- R4: While `pressed` is high, a raw high level captured at edge k makes `pressed` fall after edge k+2, with no settling delay.
- R5: Any raw activity between the first detection and the second sample is ignored. If the second sample reads high, the block returns to idle and never raises `pressed` or `press_pulse` for that attempt.
- R6: `press_pulse` is high for exactly one cycle, in the same cycle that `pressed` rises.
- R7: `release_pulse` is high for exactly one cycle, in the same cycle that `pressed` falls.
- R8: While reset (`rst_n` low) is asserted, the block is idle: `pressed`, `press_pulse` and `release_pulse` are 0, and the counter is cleared.
- R9: The raw level passes through a two-flop synchronizer before the state machine reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_raw_n | input | 1 | Raw button level; 0 = held |
| pressed | output | 1 | Confirmed-press level |
| press_pulse | output | 1 | One-cycle pulse when a press is confirmed |
| release_pulse | output | 1 | One-cycle pulse when a confirmed press ends |

## Verification
Every result lands a fixed number of edges after the edge that captures the raw level.

- A release shows on `pressed` and `release_pulse` two edges later.
- A confirmed press shows on `pressed` and `press_pulse` W+2 edges after the first low capture.
- The confirm decision depends on the raw level captured at edge k+W.

The bench keeps a behavioural model that delays the raw level through a two-entry queue and counts the wait down in an integer. It drives inputs on falling edges and compares all three outputs against the model on every falling edge, so each comparison falls half a cycle after the edge where the result is due. It also uses a low level held for exactly W edges and for W+1 edges to probe where the second sample falls.

// File: rtl/btn_confirm_debounce.sv
module btn_confirm_debounce #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned WAIT_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw_n,
  output logic pressed,
  output logic press_pulse,
  output logic release_pulse
);

  localparam longint unsigned CYC_L    = (longint'(CLK_HZ) * longint'(WAIT_MS)) / 1000;
  localparam int unsigned     WAIT_CYC = (CYC_L < 1) ? 1 : 32'(CYC_L);
  localparam int unsigned     CW       = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0]   LAST     = CW'(WAIT_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONF} st_t;

  logic          sync_a, sync_b;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          down, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= btn_raw_n;
      sync_b <= sync_a;
    end
  end

  assign down = ~sync_b;
  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      cnt           <= '0;
      press_pulse   <= 1'b0;
      release_pulse <= 1'b0;
    end else begin
      press_pulse   <= 1'b0;
      release_pulse <= 1'b0;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (down) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done) begin
            cnt <= '0;
            if (down) begin
              st          <= ST_CONF;
              press_pulse <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONF: begin
          cnt <= '0;
          if (!down) begin
            st            <= ST_IDLE;
            release_pulse <= 1'b1;
          end
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign pressed = (st == ST_CONF);

  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_cnt_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (cnt == '0));

  assert_release_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed && sync_b) |=> !pressed);

  assert_press_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);

  assert_press_with_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> press_pulse);

  assert_release_with_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pressed) |-> release_pulse);

  assert_release_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);

  assert_reject_stays_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && done && !down) |=> (!pressed && !press_pulse));

endmodule

// File: tb/btn_confirm_debounce_tb.sv
module btn_confirm_debounce_tb_top;
  localparam int unsigned HZ = 1000;
  localparam int unsigned MS = 30;
  localparam int W = HZ * MS / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b1;
  logic pressed, press_pulse, release_pulse;

  int checks = 0;
  int errors = 0;
  int press_cnt = 0;
  int rel_cnt = 0;

  always #2 clk = ~clk;

  btn_confirm_debounce #(.CLK_HZ(HZ), .WAIT_MS(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_raw_n(btn),
    .pressed(pressed), .press_pulse(press_pulse), .release_pulse(release_pulse));

  // Reference model: two-deep delay queue, integer state and countdown
  bit hist[$];
  int mst, rem;
  bit mp, mpp, mrp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1};
      mst = 0; rem = 0; mp = 0; mpp = 0; mrp = 0;
    end else begin
      bit lvl;
      lvl = hist[0];
      void'(hist.pop_front());
      hist.push_back(btn);
      mpp = 0; mrp = 0;
      if (mst == 0) begin
        if (!lvl) begin mst = 1; rem = W; end
      end else if (mst == 1) begin
        if (rem == 1) begin
          if (!lvl) begin mst = 2; mpp = 1; end else mst = 0;
        end else rem = rem - 1;
      end else if (lvl) begin
        mst = 0; mrp = 1;
      end
      mp = (mst == 2);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R4", "pressed", pressed, mp);
      chk("R6", "press_pulse", press_pulse, mpp);
      chk("R7", "release_pulse", release_pulse, mrp);
      if (press_pulse === 1'b1) press_cnt++;
      if (release_pulse === 1'b1) rel_cnt++;
    end
  end

  task automatic hold(input logic v, input int n);
    btn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic cnt_chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s event count: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "pressed in reset", pressed, 1'b0);
        chk("R8", "press_pulse in reset", press_pulse, 1'b0);
        chk("R8", "release_pulse in reset", release_pulse, 1'b0);
        rst_n = 1'b1;
        hold(1, 5);

        // R1/R3: clean press, then R4/R7 immediate release
        press_cnt = 0; rel_cnt = 0;
        hold(0, W + 20);
        chk("R1", "held button gives pressed", pressed, 1'b1);
        hold(1, 3);
        chk("R4", "pressed gone two edges after release", pressed, 1'b0);
        hold(1, 5);
        cnt_chk("R6", press_cnt, 1);
        cnt_chk("R7", rel_cnt, 1);

        // R5: bounce that ends high at the second sample is rejected
        press_cnt = 0;
        for (int i = 0; i < 6; i++) begin hold(0, 2); hold(1, 3); end
        hold(1, W + 10);
        cnt_chk("R5", press_cnt, 0);

        // R5/R3: bounce during the wait that settles low is accepted
        press_cnt = 0;
        for (int i = 0; i < 4; i++) begin hold(0, 1); hold(1, 2); end
        hold(0, W + 10);
        cnt_chk("R5", press_cnt, 1);
        hold(1, 10);

        // R3 boundary: low for exactly W edges misses the second sample
        press_cnt = 0;
        hold(0, W); hold(1, W + 10);
        cnt_chk("R3", press_cnt, 0);

        // R3 boundary: low for W+1 edges is confirmed, then released at once
        press_cnt = 0; rel_cnt = 0;
        hold(0, W + 1); hold(1, W + 10);
        cnt_chk("R3", press_cnt, 1);
        cnt_chk("R4", rel_cnt, 1);

        // R9/R4: single-cycle high glitch while confirmed ends the press
        press_cnt = 0; rel_cnt = 0;
        hold(0, W + 10); hold(1, 1); hold(0, W + 10);
        cnt_chk("R9", rel_cnt, 1);
        cnt_chk("R3", press_cnt, 2);
        hold(1, 10);

        // R8: reset during the wait clears everything
        hold(0, W / 2);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "pressed after mid-wait reset", pressed, 1'b0);
        rst_n = 1'b1;
        hold(1, W + 10);
        chk("R8", "no press after reset aborts wait", pressed, 1'b0);
        // R2: from a fresh start the press arrives after the full wait
        hold(0, W + 5);
        chk("R2", "pressed after full wait", pressed, 1'b1);
        hold(1, 10);
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule